// File: doc/BRIEF.md
# Reactive Power Sign Change Detector

This block watches a stream of signed average reactive-power samples and flags a change of sign in the direction picked by software. Every sample is presented with a valid strobe. The block keeps the sign of the last accepted sample and compares each new accepted sample against it. When the pair forms the selected kind of crossing, a sticky status flag is raised.

The flag stays high until software writes a one to the clear strobe. An interrupt request is driven while the flag is high and the interrupt enable input is high. A single direction input selects what counts as an event. With a 0 the block reports a crossing from positive to negative, and with a 1 it reports a crossing from negative to positive.

Top module: `pwr_sign_det`

## Requirements
- R1: After reset is released, `flag_o` and `irq_o` are both 0.
- R2: A sample is negative when its MSB is 1. Zero and every sample with MSB 0 count as positive.
- R3: With `dir_sel_i` = 0, a valid positive sample followed by a valid negative sample sets `flag_o` in the cycle after the negative sample is accepted.
- R4: With `dir_sel_i` = 1, a valid negative sample followed by a valid positive sample sets `flag_o` in the cycle after the positive sample is accepted.
- R5: Consecutive valid samples of the same sign never set the flag. A crossing in the direction that is not selected never sets the flag either.
- R6: A sample presented while `sample_valid_i` is 0 is ignored. It does not set the flag and does not replace the remembered sign.
- R7: The first valid sample after reset never sets the flag, whatever its sign.
- R8: Once set, `flag_o` stays 1 until `clr_i` is high at a clock edge. It is then 0 from the next cycle.
- R9: If a qualifying crossing and `clr_i` occur in the same cycle, `flag_o` is 1 in the next cycle.
- R10: `irq_o` is 1 exactly when `flag_o` is 1 and `irq_en_i` is 1.
- R11: Changing `dir_sel_i` while no valid sample arrives never sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_valid_i | input | 1 | Qualifies `sample_i` for this cycle |
| sample_i | input | DATA_W | Signed average reactive power sample |
| dir_sel_i | input | 1 | 0: report positive-to-negative; 1: report negative-to-positive |
| irq_en_i | input | 1 | Interrupt enable for the sign flag |
| clr_i | input | 1 | Write-one-to-clear strobe for the sign flag |
| flag_o | output | 1 | Sticky sign-change status flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with `DATA_W` = 4. At that width it can feed every ordered pair of the 16 sample codes under both direction settings and both enable settings. This covers zero, the most negative code, and all boundary pairs around the sign bit. Expected flags come from the sign bits alone. Directed sequences then cover the first sample after reset, ignored invalid samples, set colliding with clear, and direction changes made without a valid sample.

// File: rtl/pwr_sign_pkg.sv
package pwr_sign_pkg;
  typedef enum logic {
    DIR_POS2NEG = 1'b0,
    DIR_NEG2POS = 1'b1
  } dir_e;

  typedef enum logic {
    SGN_POS = 1'b0,
    SGN_NEG = 1'b1
  } sgn_e;
endpackage

// File: rtl/sign_classify.sv
module sign_classify
  import pwr_sign_pkg::*;
#(
  parameter int unsigned DATA_W = 24
) (
  input  logic [DATA_W-1:0] sample_i,
  output sgn_e              sgn_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic is_zero;
  assign is_zero = (sample_i == '0);
  // zero is classed positive explicitly (R2)
  assign sgn_o = (sample_i[MSB] && !is_zero) ? SGN_NEG : SGN_POS;
endmodule

// File: rtl/sign_history.sv
module sign_history
  import pwr_sign_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  sgn_e sgn_i,
  output sgn_e prev_sgn_o,
  output logic primed_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_sgn_o <= SGN_POS;
      primed_o   <= 1'b0;
    end else if (valid_i) begin
      prev_sgn_o <= sgn_i;
      primed_o   <= 1'b1;
    end
  end

  p_prev_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(prev_sgn_o));
  p_primed_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    primed_o |=> primed_o);
endmodule

// File: rtl/edge_qualify.sv
module edge_qualify
  import pwr_sign_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic primed_i,
  input  dir_e dir_i,
  input  sgn_e prev_sgn_i,
  input  sgn_e cur_sgn_i,
  output logic evt_o
);
  logic crossing;
  assign crossing = (prev_sgn_i != cur_sgn_i);

  always_comb begin
    evt_o = 1'b0;
    if (valid_i && primed_i && crossing) begin
      unique case (dir_i)
        DIR_POS2NEG: evt_o = (cur_sgn_i == SGN_NEG);
        DIR_NEG2POS: evt_o = (cur_sgn_i == SGN_POS);
      endcase
    end
  end

  p_evt_primed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> primed_i && valid_i);
endmodule

// File: rtl/status_flag.sv
module status_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;  // set beats clear (R9)
    else if (clr_i)  flag_o <= 1'b0;
  end

  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_o);
  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !clr_i |=> flag_o);
  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && clr_i && !set_i |=> !flag_o);
endmodule

// File: rtl/pwr_sign_det.sv
module pwr_sign_det
  import pwr_sign_pkg::*;
#(
  parameter int unsigned DATA_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sample_valid_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              dir_sel_i,
  input  logic              irq_en_i,
  input  logic              clr_i,
  output logic              flag_o,
  output logic              irq_o
);
  sgn_e cur_sgn, prev_sgn;
  logic primed, evt;
  dir_e dir;

  assign dir = dir_e'(dir_sel_i);

  sign_classify #(.DATA_W(DATA_W)) u_classify (
    .sample_i (sample_i),
    .sgn_o    (cur_sgn)
  );

  sign_history u_history (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (sample_valid_i),
    .sgn_i      (cur_sgn),
    .prev_sgn_o (prev_sgn),
    .primed_o   (primed)
  );

  edge_qualify u_qualify (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (sample_valid_i),
    .primed_i   (primed),
    .dir_i      (dir),
    .prev_sgn_i (prev_sgn),
    .cur_sgn_i  (cur_sgn),
    .evt_o      (evt)
  );

  status_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt),
    .clr_i  (clr_i),
    .flag_o (flag_o)
  );

  assign irq_o = flag_o & irq_en_i;

  p_no_rise_without_sample_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_valid_i |=> !$rose(flag_o));
  p_irq_needs_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> flag_o);
endmodule

// File: tb/pwr_sign_det_test.sv
`timescale 1ns/1ps
module pwr_sign_det_test;
  localparam int unsigned W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0, dir = 1'b0, en = 1'b0, clr = 1'b0;
  logic [W-1:0] smp = '0;
  logic flag, irq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  pwr_sign_det #(.DATA_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(vld), .sample_i(smp),
    .dir_sel_i(dir), .irq_en_i(en), .clr_i(clr), .flag_o(flag), .irq_o(irq)
  );

  function automatic logic neg(input logic [W-1:0] x);
    return x[W-1];
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // drive inputs for one cycle, sample 2 ns after the edge
  task automatic cyc(input logic v, input logic [W-1:0] d, input logic c);
    vld = v; smp = d; clr = c;
    @(posedge clk); #2;
    vld = 1'b0; clr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; vld = 1'b0; clr = 1'b0;
    @(posedge clk); #2;
    rst_n = 1'b1;
    @(posedge clk); #2;
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    logic e;
    do_reset();
    chk("R1 flag", flag, 1'b0);
    chk("R1 irq", irq, 1'b0);

    // R7: first valid sample never sets, even a negative one
    dir = 1'b0; en = 1'b1;
    cyc(1'b1, 4'h9, 1'b0);
    chk("R7 first sample", flag, 1'b0);
    cyc(1'b1, 4'h0, 1'b0);  // zero is positive (R2)
    chk("R2 zero positive under dir0", flag, 1'b0);
    cyc(1'b1, 4'h8, 1'b0);
    chk("R3 pos to neg", flag, 1'b1);
    chk("R10 irq with enable", irq, 1'b1);

    // R8: sticky while no clear
    for (int i = 0; i < 3; i++) begin
      cyc(1'b1, 4'h7, 1'b0);
      chk("R8 sticky", flag, 1'b1);
    end
    cyc(1'b0, 4'h0, 1'b1);
    chk("R8 cleared", flag, 1'b0);

    // R9: set and clear in same cycle (prev positive)
    cyc(1'b1, 4'hF, 1'b1);
    chk("R9 set beats clear", flag, 1'b1);
    cyc(1'b0, 4'h0, 1'b1);
    chk("R8 cleared again", flag, 1'b0);

    // R6: invalid positive ignored, prev stays negative
    cyc(1'b0, 4'h3, 1'b0);
    cyc(1'b1, 4'hA, 1'b0);
    chk("R6 invalid sample ignored", flag, 1'b0);
    // R6: invalid negative between positives does nothing
    cyc(1'b1, 4'h2, 1'b0);
    cyc(1'b0, 4'hC, 1'b0);
    chk("R6 invalid neg no set", flag, 1'b0);
    cyc(1'b1, 4'h5, 1'b0);
    chk("R6 prev kept positive", flag, 1'b0);

    // R11: toggling direction without samples
    for (int i = 0; i < 4; i++) begin
      dir = ~dir;
      cyc(1'b0, 4'h8, 1'b0);
      chk("R11 dir change alone", flag, 1'b0);
    end

    // R7 again after a new reset with dir1
    do_reset();
    dir = 1'b1;
    cyc(1'b1, 4'h3, 1'b0);
    chk("R7 first sample dir1", flag, 1'b0);

    // exhaustive pairs: R2 R3 R4 R5 R10
    for (int d = 0; d < 2; d++) begin
      for (int en_v = 0; en_v < 2; en_v++) begin
        for (int a = 0; a < 16; a++) begin
          for (int b = 0; b < 16; b++) begin
            dir = d[0]; en = en_v[0];
            cyc(1'b1, a[W-1:0], 1'b0);
            cyc(1'b0, '0, 1'b1);
            chk("R8 pre-clear", flag, 1'b0);
            cyc(1'b1, b[W-1:0], 1'b0);
            e = d[0] ? (neg(a[W-1:0]) && !neg(b[W-1:0]))
                     : (!neg(a[W-1:0]) && neg(b[W-1:0]));
            chk(d[0] ? "R4 R5 pair dir1" : "R3 R5 pair dir0", flag, e);
            chk("R10 irq gating", irq, e & en_v[0]);
          end
        end
      end
    end
    summary();
  end
endmodule